// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Controller with Pixel Blink

This block is the digital timing and data core of a multiplexed segment LCD driver. It steps through the common lines in frames, with each common period split into two halves of opposite polarity. For every segment line it produces a coded drive level from a display memory in which each register holds one pixel per common. An external analog bias stage turns the 2-bit level codes into voltages. Two duty modes are supported: 1/4 duty, which scans four commons, and 1/3 duty, which scans three.

Two segment drivers, segments 18 and 19, can blink. Each of them has a 4-bit map that marks which of its pixels blink. A single rate input selects a blink period of 2 s (0.5 Hz) or 1 s (1 Hz). Timing is paced by a slow reference tick, given as a one-cycle enable. The display memory is written through a simple write port and can be read back through a registered read port, so registers that are not shown on the glass can still serve as storage.

Top module: `lcd_mux_ctrl`

## Requirements
- R1: After a synchronous reset, the outputs are as follows. Common 0 is selected in the first half, and every other common is at non-select. Every segment is unlit. The blink phase is "on". All display registers read 0.
- R2: A half period lasts HALF_TICKS reference ticks. The polarity flips after every half. The common advances after the second half, in ascending order, and wraps from the last active common to common 0.
- R3: With duty3=1, only commons 0..2 are scanned. Common 3 stays at non-select, and bit 3 of every register is never displayed. A change of duty3 takes effect at the next common boundary.
- R4: The level codes on com_lvl[2c+1:2c] and seg_lvl[2s+1:2s] are fixed for each half. In the first half, a selected common drives 3, a non-selected common 1, a lit segment 0 and an unlit segment 2. In the second half, these become 0, 2, 3 and 1 respectively.
- R5: While common k is selected, segment s is lit exactly when bit k of register s is 1. The only exception is the blink case in R7.
- R6: A write to a display register changes the segment outputs only from the next common boundary onward, never inside a common period.
- R7: Bit k of blk_map_a (for segment 18) or blk_map_b (for segment 19) makes the pixel on common k blink. While the blink phase is "off", that pixel is unlit whatever its stored bit. All other pixels and segments show their stored bit steadily.
- R8: The blink phase toggles every 2*BLINK_HALF_TICKS ticks when blink_1hz=0, and every BLINK_HALF_TICKS ticks when blink_1hz=1. A rate change is sampled only when the phase toggles.
- R9: rd_data returns register rd_addr one clock after rd_addr is presented. Writes to an address of NUM_SEG or above are ignored, and reads from such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle reference tick enable |
| duty3 | input | 1 | 1 selects 1/3 duty (three commons), 0 selects 1/4 duty |
| blink_1hz | input | 1 | Blink rate: 1 selects 1 Hz, 0 selects 0.5 Hz |
| blk_map_a | input | 4 | Per-common blink map for segment 18 |
| blk_map_b | input | 4 | Per-common blink map for segment 19 |
| wr_en | input | 1 | Display register write strobe |
| wr_addr | input | ADDR_W | Register index to write |
| wr_data | input | 4 | Pixel bits, bit k for common k |
| rd_addr | input | ADDR_W | Register index to read |
| rd_data | output | 4 | Registered read data |
| com_lvl | output | 8 | 2-bit level code per common |
| seg_lvl | output | 2*NUM_SEG | 2-bit level code per segment |

## Verification
The assertions assume the following about the inputs. tick is a single-cycle enable. The duty and blink-map inputs are sampled only at common boundaries, so changes to them between boundaries are harmless. Reset is held for at least one clock before any property is checked. The bench generates ticks at irregular intervals and writes or reads random registers in random cycles, including out-of-range addresses. It switches the duty and rate inputs in the middle of a frame, and therefore relies on the boundary-sampling rules rather than avoiding them. Every stimulus stays inside the assumptions above.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LV0 = 2'd0;
  localparam lvl_t LV1 = 2'd1;
  localparam lvl_t LV2 = 2'd2;
  localparam lvl_t LV3 = 2'd3;

  // Common drive: select swings to the rails, non-select stays near the middle
  function automatic lvl_t com_level(input logic sel, input logic pol);
    if (sel) return pol ? LV0 : LV3;
    return pol ? LV2 : LV1;
  endfunction

  // Segment drive: lit opposes the selected common, unlit stays near the middle
  function automatic lvl_t seg_level(input logic on, input logic pol);
    if (on) return pol ? LV3 : LV0;
    return pol ? LV1 : LV2;
  endfunction
endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
  parameter int HALF_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       duty3,
  output logic [1:0] com_idx,
  output logic       pol,
  output logic [1:0] next_com,
  output logic       load
);
  localparam int HC_W = $clog2(HALF_TICKS + 1);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_TICKS - 1);

  logic [HC_W-1:0] hc;
  logic [1:0]      last_com;
  logic            half_end;

  assign last_com = duty3 ? 2'd2 : 2'd3;
  assign next_com = (com_idx >= last_com) ? 2'd0 : com_idx + 2'd1;
  assign half_end = tick && (hc == HC_LAST);
  assign load     = half_end && pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= '0;
      pol     <= 1'b0;
      com_idx <= 2'd0;
    end else if (tick) begin
      if (half_end) begin
        hc  <= '0;
        pol <= ~pol;
        if (pol) com_idx <= next_com;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(pol) && $stable(com_idx))); // R2
  AST_SKIP_COM3: assert property (@(posedge clk) disable iff (rst)
    (load && duty3) |=> (com_idx != 2'd3)); // R3
  AST_COM_STEP: assert property (@(posedge clk) disable iff (rst)
    (load && !duty3 && com_idx != 2'd3) |=> (com_idx == $past(com_idx) + 2'd1)); // R2
endmodule

// File: rtl/lcd_blink.sv
module lcd_blink #(
  parameter int BLINK_HALF_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rate_1hz,
  output logic blink_on
);
  localparam int CNT_W = $clog2(2 * BLINK_HALF_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             rate_q;
  logic             phase_end;

  assign lim       = rate_q ? CNT_W'(BLINK_HALF_TICKS) : CNT_W'(2 * BLINK_HALF_TICKS);
  assign phase_end = tick && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      blink_on <= 1'b1;
      rate_q   <= rate_1hz;
    end else if (tick) begin
      if (phase_end) begin
        cnt      <= '0;
        blink_on <= ~blink_on;
        rate_q   <= rate_1hz;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(blink_on)); // R8
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
    !phase_end |=> $stable(rate_q)); // R8
endmodule

// File: rtl/lcd_drive.sv
module lcd_drive
  import lcd_pkg::*;
#(
  parameter int NUM_SEG = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             com_idx,
  input  logic                   pol,
  input  logic [NUM_SEG-1:0]     pix,
  output logic [7:0]             com_lvl,
  output logic [2*NUM_SEG-1:0]   seg_lvl
);
  logic [3:0] sel_seen;

  for (genvar c = 0; c < 4; c++) begin : g_com
    always_ff @(posedge clk) begin
      if (rst) com_lvl[2*c +: 2] <= com_level(c == 0, 1'b0);
      else     com_lvl[2*c +: 2] <= com_level(com_idx == 2'(c), pol);
    end
    assign sel_seen[c] = (com_lvl[2*c +: 2] == LV0) || (com_lvl[2*c +: 2] == LV3);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) seg_lvl[2*s +: 2] <= seg_level(1'b0, 1'b0);
      else     seg_lvl[2*s +: 2] <= seg_level(pix[s], pol);
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_seen) == 1); // R4
endmodule

// File: rtl/lcd_mux_ctrl.sv
module lcd_mux_ctrl #(
  parameter int NUM_SEG          = 20,
  parameter int HALF_TICKS       = 2,
  parameter int BLINK_HALF_TICKS = 8,
  parameter int BLINK_SEG_A      = 18,
  parameter int BLINK_SEG_B      = 19,
  parameter int ADDR_W           = $clog2(NUM_SEG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 duty3,
  input  logic                 blink_1hz,
  input  logic [3:0]           blk_map_a,
  input  logic [3:0]           blk_map_b,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [3:0]           wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [3:0]           rd_data,
  output logic [7:0]           com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_SEG - 1);

  logic [3:0]         mem [NUM_SEG];
  logic [NUM_SEG-1:0] pix;
  logic [NUM_SEG-1:0] pix_next;
  logic [1:0]         com_idx;
  logic [1:0]         next_com;
  logic               pol;
  logic               load;
  logic               blink_on;

  lcd_timebase #(.HALF_TICKS(HALF_TICKS)) u_timebase (
    .clk(clk), .rst(rst), .tick(tick), .duty3(duty3),
    .com_idx(com_idx), .pol(pol), .next_com(next_com), .load(load)
  );

  lcd_blink #(.BLINK_HALF_TICKS(BLINK_HALF_TICKS)) u_blink (
    .clk(clk), .rst(rst), .tick(tick), .rate_1hz(blink_1hz), .blink_on(blink_on)
  );

  // Display memory with write guard and registered read
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) mem[i] <= 4'd0;
      rd_data <= 4'd0;
    end else begin
      if (wr_en && wr_addr <= TOP_ADDR) mem[wr_addr] <= wr_data;
      rd_data <= (rd_addr <= TOP_ADDR) ? mem[rd_addr] : 4'd0;
    end
  end

  // Pixel column for the next common, with blink gating on the two capable segments
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_pix
    if (s == BLINK_SEG_A) begin : g_blink_a
      assign pix_next[s] = mem[s][next_com] && !(blk_map_a[next_com] && !blink_on);
    end else if (s == BLINK_SEG_B) begin : g_blink_b
      assign pix_next[s] = mem[s][next_com] && !(blk_map_b[next_com] && !blink_on);
    end else begin : g_steady
      assign pix_next[s] = mem[s][next_com];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       pix <= '0;
    else if (load) pix <= pix_next;
  end

  lcd_drive #(.NUM_SEG(NUM_SEG)) u_drive (
    .clk(clk), .rst(rst), .com_idx(com_idx), .pol(pol), .pix(pix),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  AST_WRITE_DEFERRED: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(pix)); // R6
  AST_BLINK_OFF_A: assert property (@(posedge clk) disable iff (rst)
    (load && !blink_on && blk_map_a[next_com]) |=> !pix[BLINK_SEG_A]); // R7
  AST_BLINK_OFF_B: assert property (@(posedge clk) disable iff (rst)
    (load && !blink_on && blk_map_b[next_com]) |=> !pix[BLINK_SEG_B]); // R7
  AST_OOR_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_addr > TOP_ADDR) |=> (rd_data == 4'd0)); // R9
endmodule

// File: tb/test_lcd_mux_ctrl.sv
module test_lcd_mux_ctrl;
  localparam int NS = 20;
  localparam int HT = 2;
  localparam int BH = 8;
  localparam int AW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          duty3 = 1'b0;
  logic          blink_1hz = 1'b0;
  logic [3:0]    blk_map_a = 4'b0101;
  logic [3:0]    blk_map_b = 4'b1110;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [3:0]    rd_data;
  logic [7:0]    com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit model_valid = 0;
  bit run_ticks = 0;

  lcd_mux_ctrl i_lcd_mux_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .duty3(duty3), .blink_1hz(blink_1hz),
    .blk_map_a(blk_map_a), .blk_map_b(blk_map_b), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  always #10 clk = ~clk;

  // Behavioural reference model
  int m_hc, m_com, m_pol, m_bcnt, m_bon, m_rate;
  bit [3:0] m_mem [NS];
  bit m_pix [NS];
  int exp_com [4];
  int exp_seg [NS];
  int exp_rd;

  function automatic int com_code(bit sel, int p);
    if (sel) return (p != 0) ? 0 : 3;
    return (p != 0) ? 2 : 1;
  endfunction

  function automatic int seg_code(bit on, int p);
    if (on) return (p != 0) ? 3 : 0;
    return (p != 0) ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hc = 0; m_com = 0; m_pol = 0; m_bcnt = 0; m_bon = 1; m_rate = blink_1hz;
      for (int s = 0; s < NS; s++) begin m_mem[s] = 0; m_pix[s] = 0; end
      for (int c = 0; c < 4; c++) exp_com[c] = com_code(c == 0, 0);
      for (int s = 0; s < NS; s++) exp_seg[s] = seg_code(1'b0, 0);
      exp_rd = 0;
    end else begin
      int last, nxt, old_bon, lim;
      for (int c = 0; c < 4; c++) exp_com[c] = com_code(c == m_com, m_pol);
      for (int s = 0; s < NS; s++) exp_seg[s] = seg_code(m_pix[s], m_pol);
      exp_rd = (int'(rd_addr) < NS) ? int'(m_mem[rd_addr]) : 0;
      old_bon = m_bon;
      last = duty3 ? 2 : 3;
      nxt = (m_com >= last) ? 0 : m_com + 1;
      if (tick) begin
        if (m_hc == HT - 1) begin
          m_hc = 0;
          if (m_pol != 0) begin
            for (int s = 0; s < NS; s++) begin
              bit b;
              b = m_mem[s][nxt];
              if (old_bon == 0 && ((s == 18 && blk_map_a[nxt]) || (s == 19 && blk_map_b[nxt]))) b = 0;
              m_pix[s] = b;
            end
            m_com = nxt;
          end
          m_pol = 1 - m_pol;
        end else m_hc++;
        lim = (m_rate != 0) ? BH : 2 * BH;
        if (m_bcnt == lim - 1) begin
          m_bcnt = 0; m_bon = 1 - m_bon; m_rate = blink_1hz;
        end else m_bcnt++;
      end
      if (wr_en && int'(wr_addr) < NS) m_mem[wr_addr] = wr_data;
    end
    model_valid = 1;
  end

  task automatic check(string tag, int got, int expv);
    checks++;
    if (got != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, expv, $time);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (model_valid && !finished) begin
      for (int c = 0; c < 4; c++)
        check($sformatf("R2 R3 R4 common %0d", c), int'(com_lvl[2*c +: 2]), exp_com[c]);
      for (int s = 0; s < NS; s++)
        check($sformatf("R4 R5 R6 R7 R8 segment %0d", s), int'(seg_lvl[2*s +: 2]), exp_seg[s]);
      check("R9 readback", int'(rd_data), exp_rd);
    end
  end

  // Irregular reference tick
  initial begin
    forever begin
      @(negedge clk);
      tick = run_ticks && ($urandom % 3 == 0);
    end
  end

  task automatic run(int n, bit oor);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 4 == 0);
      wr_addr = oor ? AW'(NS + ($urandom % (2**AW - NS))) : AW'($urandom % NS);
      wr_data = 4'($urandom);
      rd_addr = AW'($urandom % (2**AW));
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, explicitly
    check("R1 reset common 0", int'(com_lvl[1:0]), 3);
    check("R1 reset common 3", int'(com_lvl[7:6]), 1);
    check("R1 reset segment 0", int'(seg_lvl[1:0]), 2);
    check("R1 reset segment 19", int'(seg_lvl[39:38]), 2);
    check("R1 reset readback", int'(rd_data), 0);
    run_ticks = 1;
    // fill memory in order, then random traffic at 0.5 Hz
    for (int a = 0; a < NS; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = 4'($urandom);
    end
    @(negedge clk); wr_en = 1'b0;
    run(900, 0);
    blink_1hz = 1'b1;                 // R8 rate change mid-phase
    run(700, 0);
    duty3 = 1'b1;                     // R3 duty change mid-frame
    blk_map_a = 4'b1111; blk_map_b = 4'b1000;
    run(700, 0);
    run(200, 1);                      // R9 out-of-range writes ignored
    blink_1hz = 1'b0;
    duty3 = 1'b0;
    run(600, 0);
    run_ticks = 0;                    // R2 hold without ticks
    run(60, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule